// File: doc/BRIEF.md
# Status SPI master serializer

This block is the module-side master of a framed serial status link. At a fixed refresh rate it takes a snapshot of six ports' link, activity and transceiver-enable flags plus a two-bit firmware start-up state, and shifts that 20-bit word out on MOSI. During the same frame it shifts 20 bits in on MISO. Six of those received bits are active-low flags that show whether an optical module is fitted in each port's cage.

Each frame is framed by two strobes instead of a chip select. The load strobe goes high first so that an external parallel-in shift register can capture the host's inputs. The latch strobe goes high after the last shift so that an external serial-in register can present the new status on its outputs. The SPI clock comes from a divider on the system clock, so its high and low phases each last `HALF_DIV` system cycles. A new frame starts every `REFRESH_CYCLES` system cycles.

Top module: `status_spi_master`

## Requirements
- R1: Every frame has exactly 20 rising SPI clock edges. All of them fall after the load strobe has ended and before the latch strobe rises.
- R2: The transmitted word is, from bit 19 down to bit 0: firmware status [1:0] in bits 19..18, link flags for ports 6..1 in bits 17..12, activity flags for ports 6..1 in bits 11..6, and transceiver enables for ports 6..1 in bits 5..0. Input index 5 is port 6. Bit 19 is sent first.
- R3: MOSI changes only at a rising SPI clock edge. At the rising edge of bit cell k, MOSI takes transmitted bit 19-k.
- R4: MISO is sampled as the SPI clock falls, MSB first. Received bits 17..12 appear on `sfpPresentN[5:0]` only when the latch strobe ends, and the vector does not change at any other time.
- R5: Received bits 19..18 and 11..0 have no effect on any output.
- R6: The load strobe is high for `HALF_DIV` cycles. The first rising SPI clock edge comes exactly 2*`HALF_DIV` cycles after the load strobe rises.
- R7: The latch strobe rises exactly 2*`HALF_DIV` cycles after the last rising SPI clock edge, and stays high for `HALF_DIV` cycles.
- R8: The SPI clock stays high for exactly `HALF_DIV` cycles in each bit cell.
- R9: The load strobe rises once every `REFRESH_CYCLES` cycles. The first frame starts on the first cycle after reset is released.
- R10: While reset is active, both strobes and the SPI clock are low and `sfpPresentN` is all ones. A reset in the middle of a frame aborts that frame.
- R11: The status inputs are captured once, when the frame starts. Changes to them during a frame do not affect the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fwStatus | input | 2 | Firmware start-up state |
| linkUp | input | 6 | Link flag per port, index 5 = port 6 |
| portActive | input | 6 | Traffic activity flag per port |
| xcvrEnable | input | 6 | Optical transceiver enable per port |
| spiMiso | input | 1 | Serial data from host |
| spiSclk | output | 1 | SPI clock, idle low |
| spiMosi | output | 1 | Serial status data to host |
| spiLoadEn | output | 1 | Parallel-load strobe for host inputs, active high |
| spiLatchEn | output | 1 | Storage-latch strobe for host outputs, active high |
| sfpPresentN | output | 6 | Captured module-fitted flags, active low |

## Verification
The embedded assertions cover the frame's timing on every cycle:
- the count of clock rises between the two strobes;
- the gap from the load strobe to the first rise;
- the gap from the last rise to the latch strobe;
- the clock's high width and the frame spacing;
- MOSI changing only at a clock rise;
- the fitted-module vector changing only as the latch strobe ends.

The bench's scenarios are needed for the rest. They check the bit layout of the sent word against a model of the external shift register and the extraction of the six received flags. They also show that the other received bits are ignored, that inputs are captured once per frame, and that a reset in mid-frame aborts the frame and clears the output.

// File: rtl/status_spi_pkg.sv
package status_spi_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_GAP,
    S_HIGH,
    S_LOW,
    S_LATCH
  } phase_t;

  // One-cycle commands from the sequencer to the shift datapath
  typedef struct packed {
    logic loadWord;   // snapshot status inputs into the transmit register
    logic shiftOut;   // present next transmit bit (SPI clock rises)
    logic sampleIn;   // capture MISO (SPI clock falls)
    logic commit;     // publish received flags (latch strobe ends)
  } dpStrobes_t;

endpackage

// File: rtl/status_spi_ctrl.sv
module status_spi_ctrl
  import status_spi_pkg::*;
#(
  parameter int HALF_DIV       = 3,
  parameter int FRAME_BITS     = 20,
  parameter int REFRESH_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst,
  output logic       sclk,
  output logic       loadEn,
  output logic       latchEn,
  output dpStrobes_t strobes
);

  localparam int HALF_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W  = $clog2(FRAME_BITS + 1);
  localparam int REF_W  = (REFRESH_CYCLES > 1) ? $clog2(REFRESH_CYCLES) : 1;
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0]  BITS_ALL  = BIT_W'(FRAME_BITS);
  localparam logic [REF_W-1:0]  REF_LAST  = REF_W'(REFRESH_CYCLES - 1);

  phase_t            state, stateNext;
  logic [HALF_W-1:0] halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [REF_W-1:0]  refCnt;
  logic              halfEnd, frameGo;

  assign halfEnd = (halfCnt == HALF_LAST);
  assign frameGo = (state == S_IDLE) && (refCnt == '0);

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (frameGo) stateNext = S_LOAD;
      S_LOAD:  if (halfEnd) stateNext = S_GAP;
      S_GAP:   if (halfEnd) stateNext = S_HIGH;
      S_HIGH:  if (halfEnd) stateNext = S_LOW;
      S_LOW:   if (halfEnd) stateNext = (bitCnt == BITS_ALL) ? S_LATCH : S_HIGH;
      S_LATCH: if (halfEnd) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
      refCnt  <= '0;
    end else begin
      state   <= stateNext;
      halfCnt <= (stateNext != state || state == S_IDLE) ? '0 : halfCnt + 1'b1;
      if (state == S_LOAD)
        bitCnt <= '0;
      else if (state == S_HIGH && halfEnd)
        bitCnt <= bitCnt + 1'b1;
      refCnt  <= (refCnt == '0) ? REF_LAST : refCnt - 1'b1;
    end
  end

  assign sclk    = (state == S_HIGH);
  assign loadEn  = (state == S_LOAD);
  assign latchEn = (state == S_LATCH);

  always_comb begin
    strobes          = '0;
    strobes.loadWord = frameGo;
    strobes.shiftOut = halfEnd && (state == S_GAP || (state == S_LOW && bitCnt != BITS_ALL));
    strobes.sampleIn = halfEnd && (state == S_HIGH);
    strobes.commit   = halfEnd && (state == S_LATCH);
  end

  // ---------------- timing checks on the strobe and clock pins ----------------
  logic prevSclk, prevLoad, prevLatch, firstPending, seenLoad;
  int   sinceLoad, sinceRise, risesSeen;
  logic riseDet, fallDet, loadDet, latchDet;

  assign riseDet  = sclk && !prevSclk;
  assign fallDet  = !sclk && prevSclk;
  assign loadDet  = loadEn && !prevLoad;
  assign latchDet = latchEn && !prevLatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevSclk     <= 1'b0;
      prevLoad     <= 1'b0;
      prevLatch    <= 1'b0;
      firstPending <= 1'b0;
      seenLoad     <= 1'b0;
      sinceLoad    <= 0;
      sinceRise    <= 0;
      risesSeen    <= 0;
    end else begin
      prevSclk  <= sclk;
      prevLoad  <= loadEn;
      prevLatch <= latchEn;
      sinceLoad <= loadDet ? 0 : sinceLoad + 1;
      sinceRise <= riseDet ? 0 : sinceRise + 1;
      if (loadDet) begin
        risesSeen    <= 0;
        firstPending <= 1'b1;
        seenLoad     <= 1'b1;
      end else if (riseDet) begin
        risesSeen    <= risesSeen + 1;
        firstPending <= 1'b0;
      end
    end
  end

  assert_rise_count_R1: assert property (@(posedge clk) disable iff (rst)
    latchDet |-> risesSeen == FRAME_BITS);

  assert_load_setup_R6: assert property (@(posedge clk) disable iff (rst)
    (riseDet && firstPending) |-> sinceLoad == 2*HALF_DIV - 1);

  assert_latch_delay_R7: assert property (@(posedge clk) disable iff (rst)
    latchDet |-> sinceRise == 2*HALF_DIV - 1);

  assert_high_width_R8: assert property (@(posedge clk) disable iff (rst)
    fallDet |-> sinceRise == HALF_DIV - 1);

  assert_refresh_period_R9: assert property (@(posedge clk) disable iff (rst)
    (loadDet && seenLoad) |-> sinceLoad == REFRESH_CYCLES - 1);

endmodule

// File: rtl/status_spi_dp.sv
module status_spi_dp
  import status_spi_pkg::*;
#(
  parameter int PORTS   = 6,
  parameter int FW_BITS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobes_t         strobes,
  input  logic [FW_BITS-1:0] fwStatus,
  input  logic [PORTS-1:0]   linkUp,
  input  logic [PORTS-1:0]   portActive,
  input  logic [PORTS-1:0]   xcvrEnable,
  input  logic               spiMiso,
  output logic               spiMosi,
  output logic [PORTS-1:0]   sfpPresentN
);

  localparam int WORD_BITS = FW_BITS + 3 * PORTS;
  localparam int SFP_LO    = 2 * PORTS;
  // Received bits above the flag field simply fall off the top
  localparam int RX_BITS   = SFP_LO + PORTS;

  logic [WORD_BITS-1:0] txWord, txShift;
  logic [RX_BITS-1:0]   rxShift;

  assign txWord = {fwStatus, linkUp, portActive, xcvrEnable};

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift     <= '0;
      rxShift     <= '0;
      spiMosi     <= 1'b0;
      sfpPresentN <= '1;
    end else begin
      if (strobes.loadWord)
        txShift <= txWord;
      else if (strobes.shiftOut) begin
        spiMosi <= txShift[WORD_BITS-1];
        txShift <= {txShift[WORD_BITS-2:0], 1'b0};
      end
      if (strobes.sampleIn)
        rxShift <= {rxShift[RX_BITS-2:0], spiMiso};
      if (strobes.commit)
        sfpPresentN <= rxShift[SFP_LO +: PORTS];
    end
  end

endmodule

// File: rtl/status_spi_master.sv
module status_spi_master
  import status_spi_pkg::*;
#(
  parameter int PORTS          = 6,
  parameter int FW_BITS        = 2,
  parameter int HALF_DIV       = 3,
  parameter int REFRESH_CYCLES = 200
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FW_BITS-1:0] fwStatus,
  input  logic [PORTS-1:0]   linkUp,
  input  logic [PORTS-1:0]   portActive,
  input  logic [PORTS-1:0]   xcvrEnable,
  input  logic               spiMiso,
  output logic               spiSclk,
  output logic               spiMosi,
  output logic               spiLoadEn,
  output logic               spiLatchEn,
  output logic [PORTS-1:0]   sfpPresentN
);

  localparam int FRAME_BITS = FW_BITS + 3 * PORTS;

  dpStrobes_t strobes;

  status_spi_ctrl #(
    .HALF_DIV      (HALF_DIV),
    .FRAME_BITS    (FRAME_BITS),
    .REFRESH_CYCLES(REFRESH_CYCLES)
  ) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .sclk   (spiSclk),
    .loadEn (spiLoadEn),
    .latchEn(spiLatchEn),
    .strobes(strobes)
  );

  status_spi_dp #(
    .PORTS  (PORTS),
    .FW_BITS(FW_BITS)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .fwStatus   (fwStatus),
    .linkUp     (linkUp),
    .portActive (portActive),
    .xcvrEnable (xcvrEnable),
    .spiMiso    (spiMiso),
    .spiMosi    (spiMosi),
    .sfpPresentN(sfpPresentN)
  );

  assert_mosi_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    !$rose(spiSclk) |-> $stable(spiMosi));

  assert_flags_at_latch_end_R4: assert property (@(posedge clk) disable iff (rst)
    !$fell(spiLatchEn) |-> $stable(sfpPresentN));

endmodule

// File: tb/test_status_spi_master.sv
module test_status_spi_master;
  localparam int HALF_DIV = 3;
  localparam int REFRESH  = 200;
  localparam int NVEC     = 6;

  // {fw[1:0], link[5:0], act[5:0], txEn[5:0], hostWord[19:0]}
  localparam logic [39:0] VECS [NVEC] = '{
    {2'b10, 6'b000001, 6'b100000, 6'b010101, 20'h00000},
    {2'b01, 6'b111111, 6'b000000, 6'b000000, 20'hFFFFF},
    {2'b11, 6'b101010, 6'b010101, 6'b110011, 20'h35000},
    {2'b00, 6'b000000, 6'b111111, 6'b100001, 20'hC0FFF},
    {2'b10, 6'b010011, 6'b001100, 6'b111111, 20'h0A000},
    {2'b01, 6'b100000, 6'b000001, 6'b000000, 20'hF1FFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [1:0]  fwStatus = '0;
  logic [5:0]  linkUp = '0, portActive = '0, xcvrEnable = '0;
  logic        spiMiso = 1'b0;
  logic [19:0] hostWord = '0;
  logic        spiSclk, spiMosi, spiLoadEn, spiLatchEn;
  logic [5:0]  sfpPresentN;

  status_spi_master i_status_spi_master (
    .clk(clk), .rst(rst), .fwStatus(fwStatus), .linkUp(linkUp),
    .portActive(portActive), .xcvrEnable(xcvrEnable), .spiMiso(spiMiso),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiLoadEn(spiLoadEn),
    .spiLatchEn(spiLatchEn), .sfpPresentN(sfpPresentN)
  );

  int total = 0, bad = 0, cycle = 0;
  bit finished = 0;

  // Host-side model: parallel-in register loaded by the load strobe,
  // advanced after each falling clock; serial-in register fed on each rise.
  logic        prevSclk = 0, prevEn1 = 0, prevEn2 = 0, prevMosi = 0;
  logic [19:0] hostShift = '0, txCap = '0;
  int riseCnt = 0, framesDone = 0, en2Cyc = 0, lastPeriod = 0;
  int firstRiseCyc = 0, lastRiseCyc = 0, en1Cyc = 0, mosiGlitch = 0;
  int minHigh = 1000, maxHigh = 0;
  bit firstPending = 0;

  always @(negedge clk) begin
    cycle++;
    if (!rst) begin
      if (spiLoadEn && !prevEn2) begin
        lastPeriod = cycle - en2Cyc;
        en2Cyc = cycle;
        riseCnt = 0;
        txCap = '0;
        firstPending = 1;
      end
      if (spiLoadEn) begin
        hostShift = hostWord;
        spiMiso = hostShift[19];
      end
      if (spiSclk && !prevSclk) begin
        txCap = {txCap[18:0], spiMosi};
        riseCnt++;
        if (firstPending) firstRiseCyc = cycle;
        firstPending = 0;
        lastRiseCyc = cycle;
      end
      if (!spiSclk && prevSclk) begin
        if (cycle - lastRiseCyc < minHigh) minHigh = cycle - lastRiseCyc;
        if (cycle - lastRiseCyc > maxHigh) maxHigh = cycle - lastRiseCyc;
        hostShift = {hostShift[18:0], 1'b0};
        spiMiso = hostShift[19];
      end
      if (spiLatchEn && !prevEn1) en1Cyc = cycle;
      if (!spiLatchEn && prevEn1) framesDone++;
      if (spiMosi !== prevMosi && !(spiSclk && !prevSclk)) mosiGlitch++;
    end
    prevSclk = spiSclk;
    prevEn1  = spiLatchEn;
    prevEn2  = spiLoadEn;
    prevMosi = spiMosi;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitFrames(input int n);
    int target = framesDone + n;
    while (framesDone < target) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic applyVec(input int i);
    {fwStatus, linkUp, portActive, xcvrEnable, hostWord} = VECS[i];
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R9 frame progress actual=stalled expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [19:0] wordA, wordB;
    applyVec(0);
    repeat (3) @(negedge clk);
    check("R10 reset sclk", 32'(spiSclk), 0);
    check("R10 reset load strobe", 32'(spiLoadEn), 0);
    check("R10 reset latch strobe", 32'(spiLatchEn), 0);
    check("R10 reset sfp flags", 32'(sfpPresentN), 32'h3F);
    rst = 1'b0;

    // Table walk: frame i carries vector i
    for (int i = 0; i < NVEC; i++) begin
      waitFrames(1);
      check("R2 tx word", 32'(txCap), 32'(VECS[i][39:20]));
      check("R1 rises per frame", 32'(riseCnt), 20);
      check("R4/R5 sfp field", 32'(sfpPresentN), 32'(VECS[i][17:12]));
      if (i + 1 < NVEC) applyVec(i + 1);
    end

    // Frame timing
    check("R9 refresh period", 32'(lastPeriod), REFRESH);
    check("R6 load to first rise", 32'(firstRiseCyc - en2Cyc), 2 * HALF_DIV);
    check("R7 last rise to latch", 32'(en1Cyc - lastRiseCyc), 2 * HALF_DIV);
    check("R8 min high width", 32'(minHigh), HALF_DIV);
    check("R8 max high width", 32'(maxHigh), HALF_DIV);

    // R5: only bits 17..12 of the received word matter
    hostWord = 20'h3C000;
    waitFrames(1);
    check("R5 sfp with other bits clear", 32'(sfpPresentN), 32'h3C);
    hostWord = 20'hFCFFF;
    waitFrames(1);
    check("R5 sfp with other bits set", 32'(sfpPresentN), 32'h3C);

    // R11: inputs changed mid-frame do not alter the word in flight
    wordA = {2'b11, 6'h3F, 6'h00, 6'h3F};
    wordB = {2'b00, 6'h00, 6'h3F, 6'h00};
    {fwStatus, linkUp, portActive, xcvrEnable} = wordA;
    hostWord = 20'h15000;
    while (!spiLoadEn) @(negedge clk);
    repeat (20) @(negedge clk);
    {fwStatus, linkUp, portActive, xcvrEnable} = wordB;
    waitFrames(1);
    check("R11 word in flight kept", 32'(txCap), 32'(wordA));
    check("R4 sfp after frame", 32'(sfpPresentN), 32'h15);
    waitFrames(1);
    check("R11 new word next frame", 32'(txCap), 32'(wordB));

    // R10: reset in the middle of a shift
    while (!spiLoadEn) @(negedge clk);
    repeat (40) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 mid-frame reset sclk", 32'(spiSclk), 0);
    check("R10 mid-frame reset strobes", 32'({spiLoadEn, spiLatchEn}), 0);
    check("R10 mid-frame reset sfp", 32'(sfpPresentN), 32'h3F);
    rst = 1'b0;
    waitFrames(1);
    check("R10 frame after reset word", 32'(txCap), 32'(wordB));
    check("R10 frame after reset sfp", 32'(sfpPresentN), 32'h15);

    check("R3 mosi changes only at rise", 32'(mosiGlitch), 0);

    summary();
    $finish;
  end
endmodule